// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps the time of day and the calendar date in packed BCD registers: seconds, minutes, hours, day of week, day of month, month (with a century flag in its top bit) and a two-digit year. A prescaler divides the core clock by `TICKS_PER_SEC` to make one advance per second. On each advance the carry runs through seconds, minutes and hours, then through day of week, date, month and year. The block knows each month's length, including February in leap years, and keeps hours in either a 12-hour or a 24-hour format.

Software or a bus bridge loads any field through a simple one-cycle write port. A write to the seconds field restarts the sub-second prescaler, which lets the second boundary be aligned with an outside reference. All fields are outputs. A one-cycle `tick` strobe marks each advance, so that downstream alarm comparison can sample the fresh values.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs are seconds 8'h00, minutes 8'h00, hours 8'h00 (24-hour mode), day of week 8'h01, date 8'h01, month 8'h01 (century 0), year 8'h00, and `tick` is 0.
- R2: `tick` is high for exactly one cycle every `TICKS_PER_SEC` cycles. The fields already show their advanced values in the cycle where `tick` is high.
- R3: Seconds and minutes count 00 to 59 in BCD. Seconds wrapping from 59 to 00 adds one minute.
- R4: Hours bit 6 = 0 selects 24-hour mode, with hours 00 to 23 in bits 5:0. Bit 5 is the tens-of-twenty digit. Moving from 23:59:59 to 00:00:00 advances the day.
- R5: Hours bit 6 = 1 selects 12-hour mode, with bit 5 = PM and hours 01 to 12 in bits 4:0. The sequence is 11→12 with AM/PM flipped, then 12→01 with AM/PM unchanged. Only 11:59:59 PM → 12:00:00 AM advances the day.
- R6: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in every other month except 02. February wraps after 29 when the BCD year is divisible by 4 (00 included) and after 28 otherwise.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and inverts month bit 7 (century). Month bit 7 is otherwise kept across advances.
- R8: Day of week advances at each day advance and wraps from 7 to 1.
- R9: Write addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year; address 7 is ignored. Unused bits read back 0: seconds and minutes keep bits 6:0, hours keep bits 6:0 in 12-hour mode and bits 5:0 in 24-hour mode, day keeps 2:0, date keeps 5:0, month keeps bits 7 and 4:0, and year keeps all 8 bits.
- R10: A write to seconds restarts the prescaler. The next `tick` comes exactly `TICKS_PER_SEC` cycles after the write edge.
- R11: A write to a field other than seconds in the same cycle as an advance loads the written value into that field, while the other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Field write enable |
| wrAddr | input | 3 | Field select for writes |
| wrData | input | 8 | Write value (BCD) |
| secOut | output | 8 | Seconds |
| minOut | output | 8 | Minutes |
| hourOut | output | 8 | Hours with mode and AM/PM or tens-of-twenty bit |
| dowOut | output | 8 | Day of week |
| dateOut | output | 8 | Day of month |
| monthOut | output | 8 | Month, bit 7 century |
| yearOut | output | 8 | Year |
| tick | output | 1 | One-cycle once-per-second update strobe |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 8, so one second lasts eight cycles. That makes it practical to preload every field and reach each rollover one second later. At this size the bench sweeps every seconds value, all 24 hours in 24-hour mode, all 24 hour and AM/PM pairs in 12-hour mode, and the last day and the day before it in every month for both a leap year and a common year. Short seconds rewrites, each with 8 cycles left before the next tick, also make it possible to hit the exact tick cycle when testing a coincident write and the prescaler restart.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DOW = 3, F_DATE = 4, F_MONTH = 5, F_YEAR = 6;

  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] wrSel;
  } calCtl_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    logic [3:0] ones, tens;
    ones = (v[3:0] == 4'd9) ? 4'd0 : v[3:0] + 4'd1;
    tens = (v[3:0] == 4'd9) ? v[7:4] + 4'd1 : v[7:4];
    return {tens, ones};
  endfunction

  function automatic logic isLeap(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] lastDay(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return isLeap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] wrMask(input int idx, input logic [7:0] d);
    case (idx)
      F_SEC, F_MIN: return d & 8'h7F;
      F_HOUR:       return d[6] ? (d & 8'h7F) : (d & 8'h3F);
      F_DOW:        return d & 8'h07;
      F_DATE:       return d & 8'h3F;
      F_MONTH:      return d & 8'h9F;
      default:      return d;
    endcase
  endfunction

  function automatic logic [7:0] resetVal(input int idx);
    return (idx == F_DOW || idx == F_DATE || idx == F_MONTH) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/bcd_calendar_ctl.sv
module bcd_calendar_ctl
  import bcd_calendar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  output calCtl_t    ctl,
  output logic       tick
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;
  logic          wrSec;
  logic          wrap;

  assign wrSec = ctl.wrSel[F_SEC];
  assign wrap  = (cnt == LAST);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign ctl.wrSel[i] = wrEn && (wrAddr == 3'(i));
  end

  assign ctl.advance = wrap && !wrSec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= (wrSec || wrap) ? '0 : cnt + 1'b1;
      tick <= ctl.advance;
    end
  end
endmodule

// File: rtl/bcd_calendar_dp.sv
module bcd_calendar_dp
  import bcd_calendar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calCtl_t    ctl,
  input  logic [7:0] wrData,
  output logic [7:0] fieldQ [NUM_FIELDS]
);
  logic [7:0] advVal [NUM_FIELDS];

  logic [7:0] sec, min, hour, dow, date, month, year;
  logic       secC, minC, dayC, monC, yrC;
  logic [4:0] h12, h12Nx;
  logic       pmNx;
  logic [7:0] last;

  assign sec   = fieldQ[F_SEC];
  assign min   = fieldQ[F_MIN];
  assign hour  = fieldQ[F_HOUR];
  assign dow   = fieldQ[F_DOW];
  assign date  = fieldQ[F_DATE];
  assign month = fieldQ[F_MONTH];
  assign year  = fieldQ[F_YEAR];
  assign h12   = hour[4:0];
  assign last  = lastDay(month[4:0], year);

  always_comb begin
    secC = (sec == 8'h59);
    minC = secC && (min == 8'h59);
    advVal[F_SEC] = secC ? 8'h00 : bcdInc(sec);
    advVal[F_MIN] = secC ? ((min == 8'h59) ? 8'h00 : bcdInc(min)) : min;

    pmNx  = hour[5];
    h12Nx = h12;
    dayC  = 1'b0;
    if (hour[6]) begin
      if (h12 == 5'h11) begin
        h12Nx = 5'h12;
        pmNx  = ~hour[5];
        dayC  = minC && hour[5];
      end else if (h12 == 5'h12) begin
        h12Nx = 5'h01;
      end else begin
        h12Nx = bcdInc({3'b000, h12})[4:0];
      end
      advVal[F_HOUR] = minC ? {2'b01, pmNx, h12Nx} : hour;
    end else begin
      dayC = minC && (hour[5:0] == 6'h23);
      advVal[F_HOUR] = minC ? ((hour[5:0] == 6'h23) ? 8'h00 : bcdInc(hour)) : hour;
    end

    advVal[F_DOW]  = dayC ? ((dow == 8'h07) ? 8'h01 : dow + 8'h01) : dow;
    monC           = dayC && (date == last);
    advVal[F_DATE] = dayC ? (monC ? 8'h01 : bcdInc(date)) : date;
    yrC            = monC && (month[4:0] == 5'h12);
    advVal[F_MONTH][7]   = month[7] ^ (yrC && (year == 8'h99));
    advVal[F_MONTH][6:0] = monC ? (yrC ? 7'h01 : bcdInc({3'b000, month[4:0]})[6:0]) : month[6:0];
    advVal[F_YEAR] = yrC ? ((year == 8'h99) ? 8'h00 : bcdInc(year)) : year;
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)                fieldQ[i] <= resetVal(i);
      else if (ctl.wrSel[i])    fieldQ[i] <= wrMask(i, wrData);
      else if (ctl.advance)     fieldQ[i] <= advVal[i];
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_calendar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dowOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut,
  output logic       tick
);
  calCtl_t    ctl;
  logic [7:0] fieldQ [NUM_FIELDS];

  bcd_calendar_ctl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .ctl(ctl), .tick(tick)
  );

  bcd_calendar_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .fieldQ(fieldQ)
  );

  assign secOut   = fieldQ[F_SEC];
  assign minOut   = fieldQ[F_MIN];
  assign hourOut  = fieldQ[F_HOUR];
  assign dowOut   = fieldQ[F_DOW];
  assign dateOut  = fieldQ[F_DATE];
  assign monthOut = fieldQ[F_MONTH];
  assign yearOut  = fieldQ[F_YEAR];
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic [7:0] wrData,
  input logic [7:0] secOut,
  input logic [7:0] minOut,
  input logic [7:0] hourOut,
  input logic [7:0] dowOut,
  input logic [7:0] dateOut,
  input logic [7:0] monthOut,
  input logic [7:0] yearOut,
  input logic       tick
);
  // R2: the strobe never lasts two cycles
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R2: without a write, seconds only change on a tick
  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (tick || $stable(secOut)));

  // R3: a tick after a non-59 second always moves seconds
  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && secOut != 8'h59) |=> (!tick || secOut != $past(secOut)));

  // R7: year 99 to 00 on a tick flips the century bit
  p_century_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !$past(wrEn) && $past(yearOut) == 8'h99 && yearOut == 8'h00)
      |-> (monthOut[7] != $past(monthOut[7])));

  // R9: unused bits stay zero
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    secOut[7] == 1'b0 && minOut[7] == 1'b0 && hourOut[7] == 1'b0 &&
    dowOut[7:3] == 5'd0 && dateOut[7:6] == 2'd0 && monthOut[6:5] == 2'd0);

  // R10: a seconds write is never followed by a tick in the next cycle
  p_sec_write_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd0) |=> !tick);
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (.*);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  localparam int TPS = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] secOut, minOut, hourOut, dowOut, dateOut, monthOut, yearOut;
  logic       tick;

  int checks = 0, failures = 0, cycles = 0;

  always #4 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS)) dut (.*);

  function automatic logic [7:0] toBcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int monLen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
  endtask

  task automatic setAll(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
    put(3'd0, 8'h00);
    put(3'd6, yr); put(3'd5, mo); put(3'd4, dt); put(3'd3, dw);
    put(3'd2, hr); put(3'd1, mi); put(3'd0, se);
    wrEn = 1'b0;
  endtask

  task automatic waitTick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 40);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "sec", secOut, 8'h00);   chk("R1", "min", minOut, 8'h00);
    chk("R1", "hour", hourOut, 8'h00); chk("R1", "dow", dowOut, 8'h01);
    chk("R1", "date", dateOut, 8'h01); chk("R1", "month", monthOut, 8'h01);
    chk("R1", "year", yearOut, 8'h00); chk("R1", "tick", {7'd0, tick}, 8'h00);

    // R10 and R2 timing
    setAll(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h20, 8'h30);
    waitTick(n);
    chk("R10", "cycles to tick", 8'(n), 8'(TPS));
    chk("R2", "sec on tick", secOut, 8'h31);
    @(negedge clk);
    chk("R2", "tick one cycle", {7'd0, tick}, 8'h00);
    waitTick(n);
    chk("R2", "tick period", 8'(n + 1), 8'(TPS));

    // R3 seconds sweep
    for (int s = 0; s < 60; s++) begin
      setAll(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h07, toBcd(s));
      waitTick(n);
      chk("R3", "sec", secOut, toBcd((s + 1) % 60));
      chk("R3", "min", minOut, (s == 59) ? 8'h08 : 8'h07);
    end
    setAll(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h59, 8'h59);
    waitTick(n);
    chk("R3", "min wrap", minOut, 8'h00);
    chk("R3", "hour carry", hourOut, 8'h09);

    // R4 24-hour sweep, R8 day advance
    for (int h = 0; h < 24; h++) begin
      setAll(8'h24, 8'h05, 8'h10, 8'h03, toBcd(h), 8'h59, 8'h59);
      waitTick(n);
      chk("R4", "hour24", hourOut, toBcd((h + 1) % 24));
      chk("R4", "date", dateOut, (h == 23) ? 8'h11 : 8'h10);
      chk("R8", "dow", dowOut, (h == 23) ? 8'h04 : 8'h03);
    end

    // R5 12-hour sweep
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh, npm;
        logic adv;
        nh = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        adv = (h == 11) && (pm == 1);
        setAll(8'h24, 8'h05, 8'h10, 8'h03, 8'h40 | 8'(pm << 5) | toBcd(h), 8'h59, 8'h59);
        waitTick(n);
        chk("R5", "hour12", hourOut, 8'h40 | 8'(npm << 5) | toBcd(nh));
        chk("R5", "date", dateOut, adv ? 8'h11 : 8'h10);
      end
    end

    // R6 month lengths for common and leap years
    for (int yi = 0; yi < 3; yi++) begin
      int y;
      y = (yi == 0) ? 1 : (yi == 1) ? 4 : 0;
      for (int m = 1; m <= 12; m++) begin
        int len;
        len = monLen(m, y);
        setAll(toBcd(y), toBcd(m), toBcd(len - 1), 8'h02, 8'h23, 8'h59, 8'h59);
        waitTick(n);
        chk("R6", "date before end", dateOut, toBcd(len));
        chk("R6", "month hold", monthOut, toBcd(m));
        setAll(toBcd(y), toBcd(m), toBcd(len), 8'h02, 8'h23, 8'h59, 8'h59);
        waitTick(n);
        chk("R6", "date wrap", dateOut, 8'h01);
        chk("R6", "month next", monthOut, toBcd(m == 12 ? 1 : m + 1));
        chk("R7", "year", yearOut, toBcd(m == 12 ? y + 1 : y));
      end
    end

    // R7 century toggle both ways
    for (int c = 0; c < 2; c++) begin
      setAll(8'h99, 8'h12 | 8'(c << 7), 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
      waitTick(n);
      chk("R7", "year wrap", yearOut, 8'h00);
      chk("R7", "century", monthOut, 8'h01 | 8'((1 - c) << 7));
      chk("R8", "dow wrap", dowOut, 8'h01);
    end
    setAll(8'h45, 8'h86, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
    waitTick(n);
    chk("R7", "century kept", monthOut, 8'h87);

    // R9 masks and ignored address
    setAll(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h20, 8'h30);
    put(3'd3, 8'hFF); wrEn = 1'b0;
    chk("R9", "dow mask", dowOut, 8'h07);
    put(3'd0, 8'hD9); put(3'd5, 8'hFF); put(3'd2, 8'hBF); put(3'd7, 8'h55); wrEn = 1'b0;
    chk("R9", "sec mask", secOut, 8'h59);
    chk("R9", "month mask", monthOut, 8'h9F);
    chk("R9", "hour24 mask", hourOut, 8'h3F);
    chk("R9", "addr7 year", yearOut, 8'h24);
    chk("R9", "addr7 date", dateOut, 8'h10);
    put(3'd2, 8'hFF); put(3'd4, 8'hFF); wrEn = 1'b0;
    chk("R9", "hour12 mask", hourOut, 8'h7F);
    chk("R9", "date mask", dateOut, 8'h3F);

    // R11 write coincident with advance
    setAll(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h10, 8'h59);
    repeat (TPS - 1) @(negedge clk);
    put(3'd1, 8'h30); wrEn = 1'b0;
    chk("R11", "tick", {7'd0, tick}, 8'h01);
    chk("R11", "sec", secOut, 8'h00);
    chk("R11", "min written", minOut, 8'h30);
    chk("R11", "hour", hourOut, 8'h08);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule